// File: doc/BRIEF.md
# System Control Register File

A coprocessor-style bank of 32-bit system control registers, reached through one access port. A move-to operation (write) and a move-from operation (read) each name a 5-bit register number and a 3-bit select. Each register keeps the bits it owns and takes only its software-writable bits from the written value. Registers the block does not implement read as zero, and writes to them are ignored. Two read-only identity words come from parameters.

The Status register holds the interrupt mask, the global enable and three mode flags: user, error and exception. Software can write these flags, and they read back in place. The Cause register holds pending interrupt bits. Six of them follow the hardware interrupt lines, and two can be set by software. A debug-mode flag is taken from writes to the Debug register. An interrupt request is raised when a Status write turns the global enable on while a pending, unmasked interrupt is waiting. It is dropped when a Status write turns the enable off. An access whose select is not allowed for its register number is flagged and has no effect.

Top module: `sysctl_regfile`

## Requirements
- R1: An access with a nonzero select to any register number other than 16 or 28 is illegal. `illegal_o` is 1 for exactly the cycle after it. An illegal read returns 0, and an illegal write changes no register. A legal access leaves `illegal_o` at 0.
- R2: After reset, every readable register reads 0, with these exceptions: Status (12) reads 0x00000004, because its error-mode flag is set; number 15 reads `PRID_VAL`; number 16 select 1 reads `CFG1_VAL`.
- R3: A write to Index (0) keeps bit 31 and stores bits 3:0. A write to Context (4) keeps bits 31:24 and stores bits 23:4.
- R4: Stored bits are value AND mask. The masks are 0x3FFFFFFF for EntryLo0 (2) and EntryLo1 (3), 0x01FFE000 for PageMask (5), 0x0000000F for Wired (6), and 0xFFFFF0FF for EntryHi (10). Count (9), Compare (11), EPC (14), ErrorEPC (30) and number 28 select 1 store all 32 bits.
- R5: Status stores the written value AND 0xFA78FF01. Bits 4, 2 and 1 of the written value set the user, error and exception flags, which read back at those bit positions. Bit 0 is the global enable and bits 15:8 are the interrupt mask.
- R6: A write to Cause (13) changes only bits 9:8 and 23:22. Bits 15:10 show `hw_irq_i` (bit 10 = line 0), one cycle after the lines change.
- R7: `irq_o` rises after a Status write that meets all of these: it changes bit 0 from 0 to 1; the written bits 2 and 1 are both 0; the debug flag is clear; and (written bits 15:8 AND Cause bits 15:8) is nonzero.
- R8: A Status write that changes bit 0 from 1 to 0 clears `irq_o`. A Status write that leaves bit 0 unchanged does not change `irq_o`.
- R9: A read of number 17 returns the full stored 32-bit value shifted right by 4.
- R10: Debug (23) stores the written value AND 0x13300120. Written bit 30 sets the debug flag, which reads back at bit 30 and blocks R7.
- R11: Number 16 select 0 stores only bit 0. Number 28 select 0 stores the value AND 0xFFFFFCF6. Numbers 15 and 16 select 1 ignore writes.
- R12: Read data appears on `rdata_o` the cycle after a read and holds until the next read. Legal numbers that are not implemented (1, 7, 8, 18 to 22, 24 to 27, 29, 31, and 16 or 28 with select 2 to 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Access strobe, one operation per cycle |
| we_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| reg_num_i | input | 5 | Register number |
| sel_i | input | 3 | Register select |
| wdata_i | input | 32 | Write value |
| hw_irq_i | input | 6 | Hardware interrupt lines into Cause 15:10 |
| rdata_o | output | 32 | Registered read data |
| illegal_o | output | 1 | One-cycle illegal-access flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every result is one register stage away from its access. A write is visible to a read issued in the next cycle. Read data, `illegal_o` and `irq_o` all settle on the edge that takes the access. Cause bits 15:10 trail `hw_irq_i` by one edge. The bench drives each access half a period before the edge and drops it half a period after. It samples every output at that falling edge, so each check sees exactly the value owed one edge after its stimulus. Waits of two edges are inserted only around changes of the hardware interrupt lines.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN     = 32;
  localparam int NUM_W    = 5;
  localparam int SEL_W    = 3;
  localparam int HWI_W    = 6;
  localparam int HWI_LSB  = 10;
  localparam int IM_LSB   = 8;
  localparam int IM_W     = 8;
  localparam int NSLOT    = 18;
  localparam int SLOT_W   = $clog2(NSLOT + 1);

  localparam logic [NUM_W-1:0] RN_STATUS = 5'd12;
  localparam logic [NUM_W-1:0] RN_PRID   = 5'd15;
  localparam logic [NUM_W-1:0] RN_CFG    = 5'd16;
  localparam logic [NUM_W-1:0] RN_LLA    = 5'd17;
  localparam logic [NUM_W-1:0] RN_DEBUG  = 5'd23;
  localparam logic [NUM_W-1:0] RN_CACHE  = 5'd28;

  localparam logic [XLEN-1:0] STATUS_WMASK = 32'hFA78_FF01;
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int DBG_DM = 30;

  typedef enum logic [SLOT_W-1:0] {
    SL_INDEX, SL_ELO0, SL_ELO1, SL_CTX, SL_PMASK, SL_WIRED,
    SL_COUNT, SL_EHI, SL_CMP, SL_STATUS, SL_CAUSE, SL_EPC,
    SL_CFG0, SL_LLA, SL_DEBUG, SL_TAGLO, SL_DATALO, SL_ERREPC,
    SL_NONE
  } slot_e;

  typedef enum logic [1:0] {RO_NONE, RO_PRID, RO_CFG1} ro_e;

  function automatic logic [XLEN-1:0] slot_wmask(slot_e s);
    case (s)
      SL_INDEX:  return 32'h0000_000F;
      SL_ELO0,
      SL_ELO1:   return 32'h3FFF_FFFF;
      SL_CTX:    return 32'h00FF_FFF0;
      SL_PMASK:  return 32'h01FF_E000;
      SL_WIRED:  return 32'h0000_000F;
      SL_EHI:    return 32'hFFFF_F0FF;
      SL_STATUS: return STATUS_WMASK;
      SL_CAUSE:  return 32'h00C0_0300;
      SL_CFG0:   return 32'h0000_0001;
      SL_DEBUG:  return 32'h1330_0120;
      SL_TAGLO:  return 32'hFFFF_FCF6;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] slot_keep(slot_e s);
    case (s)
      SL_INDEX: return 32'h8000_0000;
      SL_CTX:   return 32'hFF00_0000;
      SL_CAUSE: return 32'hB000_F87C;
      SL_CFG0:  return 32'hFE17_FF80;
      SL_DEBUG: return 32'h8C03_FC1F;
      default:  return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [NUM_W-1:0] num_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             illegal_o,
  output slot_e            slot_o,
  output ro_e              ro_o
);
  logic sel_ok;
  assign sel_ok    = (sel_i == '0) || (num_i == RN_CFG) || (num_i == RN_CACHE);
  assign illegal_o = !sel_ok;

  always_comb begin
    slot_o = SL_NONE;
    ro_o   = RO_NONE;
    if (sel_ok) begin
      case (num_i)
        5'd0:     slot_o = SL_INDEX;
        5'd2:     slot_o = SL_ELO0;
        5'd3:     slot_o = SL_ELO1;
        5'd4:     slot_o = SL_CTX;
        5'd5:     slot_o = SL_PMASK;
        5'd6:     slot_o = SL_WIRED;
        5'd9:     slot_o = SL_COUNT;
        5'd10:    slot_o = SL_EHI;
        5'd11:    slot_o = SL_CMP;
        RN_STATUS: slot_o = SL_STATUS;
        5'd13:    slot_o = SL_CAUSE;
        5'd14:    slot_o = SL_EPC;
        RN_PRID:  ro_o   = RO_PRID;
        RN_CFG: begin
          if (sel_i == 3'd0)      slot_o = SL_CFG0;
          else if (sel_i == 3'd1) ro_o   = RO_CFG1;
        end
        RN_LLA:   slot_o = SL_LLA;
        RN_DEBUG: slot_o = SL_DEBUG;
        RN_CACHE: begin
          if (sel_i == 3'd0)      slot_o = SL_TAGLO;
          else if (sel_i == 3'd1) slot_o = SL_DATALO;
        end
        5'd30:    slot_o = SL_ERREPC;
        default:  slot_o = SL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  slot_e                      wslot_i,
  input  logic [XLEN-1:0]            wdata_i,
  input  logic [HWI_W-1:0]           hw_irq_i,
  output logic [NSLOT-1:0][XLEN-1:0] slot_q_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [XLEN-1:0] KEEP  = slot_keep(slot_e'(s));
    localparam logic [XLEN-1:0] WMASK = slot_wmask(slot_e'(s));
    logic [XLEN-1:0] q, d;

    always_comb begin
      d = q;
      if (wr_en_i && (wslot_i == slot_e'(s))) d = (q & KEEP) | (wdata_i & WMASK);
    end

    if (s == int'(SL_CAUSE)) begin : g_hw
      // hardware pending lines override whatever the write left
      logic [XLEN-1:0] d_hw;
      always_comb begin
        d_hw = d;
        d_hw[HWI_LSB +: HWI_W] = hw_irq_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_hw;
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign slot_q_o[s] = q;
  end
endmodule

// File: rtl/sysctl_mode.sv
module sysctl_mode
  import sysctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            st_wr_i,
  input  logic [XLEN-1:0] st_new_i,
  input  logic [XLEN-1:0] st_old_i,
  input  logic [IM_W-1:0] cause_im_i,
  input  logic            new_um_i,
  input  logic            new_erl_i,
  input  logic            new_exl_i,
  input  logic            dbg_wr_i,
  input  logic            new_dm_i,
  output logic            um_o,
  output logic            erl_o,
  output logic            exl_o,
  output logic            dm_o,
  output logic            irq_o
);
  logic ie_rise, ie_fall, pend, raise;

  assign ie_rise = st_new_i[ST_IE] && !st_old_i[ST_IE];
  assign ie_fall = !st_new_i[ST_IE] && st_old_i[ST_IE];
  assign pend    = |(st_new_i[IM_LSB +: IM_W] & cause_im_i);
  // mode flags checked are the ones this same write installs
  assign raise   = st_wr_i && ie_rise && !new_exl_i && !new_erl_i && !dm_o && pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      um_o  <= 1'b0;
      erl_o <= 1'b1;
      exl_o <= 1'b0;
    end else if (st_wr_i) begin
      um_o  <= new_um_i;
      erl_o <= new_erl_i;
      exl_o <= new_exl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       dm_o <= 1'b0;
    else if (dbg_wr_i) dm_o <= new_dm_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  irq_o <= 1'b0;
    else if (raise)               irq_o <= 1'b1;
    else if (st_wr_i && ie_fall)  irq_o <= 1'b0;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] PRID_VAL = 32'h0001_8A20,
  parameter logic [31:0] CFG1_VAL = 32'h1E19_0C8A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic        we_i,
  input  logic [4:0]  reg_num_i,
  input  logic [2:0]  sel_i,
  input  logic [31:0] wdata_i,
  input  logic [5:0]  hw_irq_i,
  output logic [31:0] rdata_o,
  output logic        illegal_o,
  output logic        irq_o
);
  logic                       dec_illegal;
  slot_e                      dec_slot;
  ro_e                        dec_ro;
  logic                       wr_ok;
  logic [NSLOT-1:0][XLEN-1:0] slot_q;
  logic [XLEN-1:0]            status_q, cause_q, st_new, rd_val;
  logic                       um_q, erl_q, exl_q, dm_q;
  logic                       st_wr, dbg_wr;

  sysctl_decode u_decode (
    .num_i    (reg_num_i),
    .sel_i    (sel_i),
    .illegal_o(dec_illegal),
    .slot_o   (dec_slot),
    .ro_o     (dec_ro)
  );

  assign wr_ok  = acc_i && we_i && !dec_illegal;
  assign st_wr  = wr_ok && (dec_slot == SL_STATUS);
  assign dbg_wr = wr_ok && (dec_slot == SL_DEBUG);

  sysctl_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_ok),
    .wslot_i (dec_slot),
    .wdata_i (wdata_i),
    .hw_irq_i(hw_irq_i),
    .slot_q_o(slot_q)
  );

  assign status_q = slot_q[SL_STATUS];
  assign cause_q  = slot_q[SL_CAUSE];
  assign st_new   = wdata_i & STATUS_WMASK;

  sysctl_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_wr_i   (st_wr),
    .st_new_i  (st_new),
    .st_old_i  (status_q),
    .cause_im_i(cause_q[IM_LSB +: IM_W]),
    .new_um_i  (wdata_i[ST_UM]),
    .new_erl_i (wdata_i[ST_ERL]),
    .new_exl_i (wdata_i[ST_EXL]),
    .dbg_wr_i  (dbg_wr),
    .new_dm_i  (wdata_i[DBG_DM]),
    .um_o      (um_q),
    .erl_o     (erl_q),
    .exl_o     (exl_q),
    .dm_o      (dm_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (dec_slot != SL_NONE) rd_val = slot_q[dec_slot];
    case (dec_slot)
      SL_STATUS: begin
        rd_val[ST_UM]  = um_q;
        rd_val[ST_ERL] = erl_q;
        rd_val[ST_EXL] = exl_q;
      end
      SL_DEBUG: rd_val[DBG_DM] = dm_q;
      SL_LLA:   rd_val = slot_q[SL_LLA] >> 4;
      SL_NONE: begin
        if (dec_ro == RO_PRID)      rd_val = PRID_VAL;
        else if (dec_ro == RO_CFG1) rd_val = CFG1_VAL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= acc_i && dec_illegal;
      if (acc_i && !we_i) rdata_o <= dec_illegal ? '0 : rd_val;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_i,
  input logic        we_i,
  input logic [4:0]  reg_num_i,
  input logic [2:0]  sel_i,
  input logic [31:0] wdata_i,
  input logic        illegal_o,
  input logic        irq_o,
  input logic [31:0] status_q,
  input logic [31:0] cause_q
);
  logic bad_acc, st_write;
  assign bad_acc  = acc_i && (sel_i != 3'd0) && (reg_num_i != 5'd16) && (reg_num_i != 5'd28);
  assign st_write = acc_i && we_i && (reg_num_i == 5'd12) && (sel_i == 3'd0);

  assert_illegal_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> illegal_o);

  assert_illegal_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i || !bad_acc) |=> !illegal_o);

  assert_illegal_nochange_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> ($stable(status_q) && $stable(cause_q[9:8]) && $stable(cause_q[23:22])));

  assert_status_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_write |=> ((status_q & ~32'hFA78_FF01) == 32'h0));

  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(st_write && wdata_i[0] && !wdata_i[1] && !wdata_i[2]));

  assert_irq_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_write && !wdata_i[0] && status_q[0]) |=> !irq_o);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .acc_i    (acc_i),
  .we_i     (we_i),
  .reg_num_i(reg_num_i),
  .sel_i    (sel_i),
  .wdata_i  (wdata_i),
  .illegal_o(illegal_o),
  .irq_o    (irq_o),
  .status_q (status_q),
  .cause_q  (cause_q)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  localparam logic [31:0] PRID = 32'h0001_8A20;
  localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0, we_i = 1'b0;
  logic [4:0]  reg_num_i = '0;
  logic [2:0]  sel_i = '0;
  logic [31:0] wdata_i = '0;
  logic [5:0]  hw_irq_i = '0;
  logic [31:0] rdata_o;
  logic        illegal_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysctl_regfile #(.PRID_VAL(PRID), .CFG1_VAL(CFG1)) u_sysctl_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .acc_i(acc_i), .we_i(we_i),
    .reg_num_i(reg_num_i), .sel_i(sel_i), .wdata_i(wdata_i), .hw_irq_i(hw_irq_i),
    .rdata_o(rdata_o), .illegal_o(illegal_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_i = 1'b1; we_i = we; reg_num_i = n; sel_i = s; wdata_i = d;
    @(negedge clk);
    acc_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    access(1'b0, n, s, '0);
    v = rdata_o;
  endtask

  function automatic logic [31:0] rst_val(int n, int s);
    if (n == 12) return 32'h4;
    if (n == 15) return PRID;
    if (n == 16 && s == 1) return CFG1;
    return 32'h0;
  endfunction

  // read-back value expected after writing p to (n,s) from a cleared state
  function automatic logic [31:0] wr_exp(int n, int s, logic [31:0] p);
    if (n == 16) return (s == 0) ? (p & 32'h1) : ((s == 1) ? CFG1 : 32'h0);
    if (n == 28) return (s == 0) ? (p & 32'hFFFF_FCF6) : ((s == 1) ? p : 32'h0);
    case (n)
      0:  return p & 32'h0000_000F;
      2, 3: return p & 32'h3FFF_FFFF;
      4:  return p & 32'h00FF_FFF0;
      5:  return p & 32'h01FF_E000;
      6:  return p & 32'h0000_000F;
      9, 11, 14, 30: return p;
      10: return p & 32'hFFFF_F0FF;
      12: return p & 32'hFA78_FF17;
      13: return p & 32'h00C0_0300;
      15: return PRID;
      17: return p >> 4;
      23: return p & 32'h5330_0120;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(int n, int s);
    case (n)
      0, 4: return "R3";
      2, 3, 5, 6, 9, 10, 11, 14, 30: return "R4";
      12: return "R5";
      13: return "R6";
      17: return "R9";
      23: return "R10";
      15: return "R11";
      16: return (s == 0 || s == 1) ? "R11" : "R12";
      28: return (s == 0) ? "R11" : ((s == 1) ? "R4" : "R12");
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    logic [31:0] pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset illegal_o", {31'b0, illegal_o}, 32'h0);
    chk("R7 reset irq_o", {31'b0, irq_o}, 32'h0);

    // R2: reset values of every legal (number, select 0/1)
    for (int n = 0; n < 32; n++) begin
      rd(5'(n), 3'd0, v);
      chk($sformatf("R2 reset n=%0d", n), v, rst_val(n, 0));
    end
    rd(5'd16, 3'd1, v); chk("R2 reset cfg1", v, CFG1);
    rd(5'd28, 3'd1, v); chk("R2 reset n28s1", v, 32'h0);

    // R1: exhaustive number x select sweep of the illegal flag (reads)
    for (int n = 0; n < 32; n++)
      for (int s = 0; s < 8; s++) begin
        bit bad;
        bad = (s != 0) && (n != 16) && (n != 28);
        rd(5'(n), 3'(s), v);
        chk($sformatf("R1 illegal n=%0d s=%0d", n, s), {31'b0, illegal_o}, {31'b0, bad});
        if (bad) chk("R1 illegal read data", v, 32'h0);
      end
    rd(5'd0, 3'd0, v);
    chk("R1 flag drops after legal", {31'b0, illegal_o}, 32'h0);

    // R3/R4/R5/R6/R9/R10/R11/R12: write-then-read mask sweep
    for (int n = 0; n < 32; n++)
      for (int s = 0; s < 8; s++) begin
        if ((s != 0) && (n != 16) && (n != 28)) continue;
        foreach (pats[k]) begin
          access(1'b1, 5'(n), 3'(s), pats[k]);
          rd(5'(n), 3'(s), v);
          chk($sformatf("%s mask n=%0d s=%0d p=%h", tag_for(n, s), n, s, pats[k]), v,
              wr_exp(n, s, pats[k]));
        end
      end

    // R12: read data holds over a write and an idle cycle
    access(1'b1, 5'd9, 3'd0, 32'h1234_5678);
    rd(5'd9, 3'd0, v);
    access(1'b1, 5'd9, 3'd0, 32'h0);
    @(negedge clk);
    chk("R12 rdata holds", rdata_o, 32'h1234_5678);

    // R1: illegal write changes nothing
    access(1'b1, 5'd11, 3'd0, 32'hCAFE_F00D);
    access(1'b1, 5'd11, 3'd2, 32'h0);
    chk("R1 illegal write flag", {31'b0, illegal_o}, 32'h1);
    rd(5'd11, 3'd0, v);
    chk("R1 illegal write ignored", v, 32'hCAFE_F00D);
    access(1'b1, 5'd12, 3'd3, 32'hFFFF_FFFF);
    rd(5'd12, 3'd0, v);
    chk("R1 illegal status write ignored", v, 32'h0);

    // R6: hardware lines into Cause 15:10, write keeps them
    hw_irq_i = 6'b101010;
    @(negedge clk); @(negedge clk);
    rd(5'd13, 3'd0, v); chk("R6 hw pending", v, 32'h0000_A800);
    access(1'b1, 5'd13, 3'd0, 32'hFFFF_FFFF);
    rd(5'd13, 3'd0, v); chk("R6 write keeps hw", v, 32'h00C0_AB00);
    access(1'b1, 5'd13, 3'd0, 32'h0);
    hw_irq_i = 6'b000001;
    @(negedge clk); @(negedge clk);

    // R7/R8: interrupt raise and drop
    access(1'b1, 5'd12, 3'd0, 32'h0000_0400);
    chk("R7 no irq while IE off", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0401);
    chk("R7 raise on IE rise", {31'b0, irq_o}, 32'h1);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0401);
    chk("R8 IE held keeps irq", {31'b0, irq_o}, 32'h1);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0400);
    chk("R8 drop on IE fall", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0403);
    chk("R7 blocked by exception flag", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0400);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0405);
    chk("R7 blocked by error flag", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0400);
    hw_irq_i = 6'b0;
    access(1'b1, 5'd13, 3'd0, 32'h0000_0100);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0201);
    chk("R7 unmasked mismatch no irq", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0100);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0101);
    chk("R7 software pending raise", {31'b0, irq_o}, 32'h1);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0100);
    chk("R8 software drop", {31'b0, irq_o}, 32'h0);

    // R10: debug flag blocks the raise
    access(1'b1, 5'd23, 3'd0, 32'h4000_0000);
    rd(5'd23, 3'd0, v); chk("R10 debug flag readback", v, 32'h4000_0000);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0101);
    chk("R10 debug blocks irq", {31'b0, irq_o}, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0100);
    access(1'b1, 5'd23, 3'd0, 32'h0);
    access(1'b1, 5'd12, 3'd0, 32'h0000_0101);
    chk("R10 cleared debug allows irq", {31'b0, irq_o}, 32'h1);

    // R3: Index and Context keep fields stay clear of write data
    access(1'b1, 5'd4, 3'd0, 32'hFF00_0000);
    rd(5'd4, 3'd0, keep); chk("R3 context upper kept", keep, 32'h0);
    access(1'b1, 5'd0, 3'd0, 32'h8000_0003);
    rd(5'd0, 3'd0, keep); chk("R3 index bit31 kept", keep, 32'h3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule